// File: doc/BRIEF.md
# Keyboard Scan Code Decoder

This block sits behind a keyboard serial receiver. It takes one byte per cycle, an 8-bit code with a one-cycle valid strobe, and turns the byte stream into key events. Each event holds the final key code, an extended flag, a released flag and an ASCII character. The extended prefix (0xE0) and the release prefix (0xF0) are taken in and become flags on the next key code. They never appear as events of their own.

The block tracks the two shift keys so that letters come out in upper or lower case. With the trap option set, shift keys only drive a status pin and produce no event. An event is held on the outputs with a ready flag until the consumer pulses a read strobe.

Top module: `kbd_scan_decoder`

## Requirements
- R1: A valid byte 0xE0 produces no event and marks the next key code's event as extended (ev_ext=1).
- R2: A valid byte 0xF0 produces no event and marks the next key code's event as released (ev_rel=1).
- R3: The held extended and released flags clear on every non-prefix byte, including a trapped shift code. An event carries only the flags of its own prefix sequence, so 0xE0 0x11 reports ev_ext=1 and a following bare 0x11 reports ev_ext=0.
- R4: Left shift is code 0x12 and right shift is code 0x59. shift_on goes high one cycle after either key's make code. It stays high while either key is down. A break sequence (0xF0, then the key code) clears only that key.
- R5: Letter codes map to lowercase ASCII when shift_on is low and to uppercase when it is high. Examples: 0x1C gives 'a'/'A', 0x1A gives 'z'/'Z', 0x2D gives 'r'/'R'.
- R6: The mappings below do not depend on shift. Digits map to '0'..'9' (0x16 is '1', 0x45 is '0'). Space 0x29 gives 0x20, enter 0x5A gives 0x0D and tab 0x0D gives 0x09. Every code with no mapping (for example 0x76 or 0x11) gives 0x00.
- R7: With TRAP_SHIFT=1, shift make and break codes raise no event; their state is seen only on shift_on.
- R8: With TRAP_SHIFT=0, shift codes are emitted as ordinary events with ev_ascii=0x00.
- R9: An event sets ev_ready one cycle after its byte. ev_ready stays high until a one-cycle rd_ack and falls the cycle after it. A new event while ev_ready is high overwrites the held data. An event in the same cycle as rd_ack wins, leaving ev_ready high with the new data.
- R10: Synchronous reset clears ev_ready, the event outputs, both held prefix flags and both shift key states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_in | input | 8 | Received code byte |
| byte_vld | input | 1 | One-cycle strobe qualifying byte_in |
| rd_ack | input | 1 | One-cycle read strobe from the consumer |
| ev_ready | output | 1 | A key event is held on the event outputs |
| ev_code | output | 8 | Final key code of the held event |
| ev_ext | output | 1 | Held event was preceded by the extended prefix |
| ev_rel | output | 1 | Held event was preceded by the release prefix |
| ev_ascii | output | 8 | ASCII equivalent, 0x00 if unmapped |
| shift_on | output | 1 | Either shift key is currently pressed |

## Verification
The internal state that matters is the pair of held prefix flags and the two shift key bits, and none of them can be read directly. A prefix flag left set after a key shows up on the very next event as a wrong ev_ext or ev_rel. The case where the key in between was a trapped shift is the one that exposes a missed clear. A wrong shift bit shows up one cycle later on shift_on, and also as the wrong letter case on the next letter event. Handshake errors appear at once as ev_ready failing to rise, failing to fall, or losing a same-cycle event.

// File: rtl/kbd_dec_pkg.sv
`timescale 1ns/1ps
package kbd_dec_pkg;
   localparam int unsigned CODE_W  = 8;
   localparam int unsigned ASCII_W = 8;

   typedef struct packed {
      logic [CODE_W-1:0]  code;
      logic               ext;
      logic               rel;
      logic [ASCII_W-1:0] ascii;
   } kbd_event_t;
endpackage

// File: rtl/kbd_prefix_track.sv
`timescale 1ns/1ps
module kbd_prefix_track #(
   parameter logic [7:0] EXT_CODE = 8'hE0,
   parameter logic [7:0] REL_CODE = 8'hF0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [7:0] byte_in,
   input  logic       byte_vld,
   output logic       key_done,
   output logic       ext_hold,
   output logic       rel_hold
);
   logic is_ext, is_rel;

   assign is_ext   = byte_vld && (byte_in == EXT_CODE);
   assign is_rel   = byte_vld && (byte_in == REL_CODE);
   assign key_done = byte_vld && !is_ext && !is_rel;

   always_ff @(posedge clk) begin
      if (rst) begin
         ext_hold <= 1'b0;
         rel_hold <= 1'b0;
      end else if (key_done) begin
         ext_hold <= 1'b0;
         rel_hold <= 1'b0;
      end else begin
         if (is_ext) ext_hold <= 1'b1;
         if (is_rel) rel_hold <= 1'b1;
      end
   end

   // R3
   flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
      key_done |=> (!ext_hold && !rel_hold));
   // R1
   ext_set_chk: assert property (@(posedge clk) disable iff (rst)
      is_ext |=> ext_hold);
endmodule

// File: rtl/kbd_shift_track.sv
`timescale 1ns/1ps
module kbd_shift_track #(
   parameter logic [7:0] LSHIFT_CODE = 8'h12,
   parameter logic [7:0] RSHIFT_CODE = 8'h59
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       key_done,
   input  logic [7:0] byte_in,
   input  logic       rel_hold,
   output logic       is_shift,
   output logic       shift_on
);
   localparam int unsigned NKEYS = 2;
   logic [NKEYS-1:0] pressed;
   logic [7:0]       key_code [NKEYS];

   assign key_code[0] = LSHIFT_CODE;
   assign key_code[1] = RSHIFT_CODE;

   for (genvar k = 0; k < NKEYS; k++) begin : g_key
      always_ff @(posedge clk) begin
         if (rst)
            pressed[k] <= 1'b0;
         else if (key_done && (byte_in == key_code[k]))
            pressed[k] <= !rel_hold;
      end
   end

   assign is_shift = (byte_in == LSHIFT_CODE) || (byte_in == RSHIFT_CODE);
   assign shift_on = |pressed;

   // R4
   shift_make_chk: assert property (@(posedge clk) disable iff (rst)
      (key_done && is_shift && !rel_hold) |=> shift_on);
endmodule

// File: rtl/kbd_ascii_map.sv
`timescale 1ns/1ps
module kbd_ascii_map (
   input  logic [7:0] code,
   input  logic       upper,
   output logic [7:0] ascii
);
   logic [7:0] base;
   logic       letter;

   always_comb begin
      letter = 1'b1;
      unique case (code)
         8'h1C: base = 8'h61; 8'h32: base = 8'h62; 8'h21: base = 8'h63;
         8'h23: base = 8'h64; 8'h24: base = 8'h65; 8'h2B: base = 8'h66;
         8'h34: base = 8'h67; 8'h33: base = 8'h68; 8'h43: base = 8'h69;
         8'h3B: base = 8'h6A; 8'h42: base = 8'h6B; 8'h4B: base = 8'h6C;
         8'h3A: base = 8'h6D; 8'h31: base = 8'h6E; 8'h44: base = 8'h6F;
         8'h4D: base = 8'h70; 8'h15: base = 8'h71; 8'h2D: base = 8'h72;
         8'h1B: base = 8'h73; 8'h2C: base = 8'h74; 8'h3C: base = 8'h75;
         8'h2A: base = 8'h76; 8'h1D: base = 8'h77; 8'h22: base = 8'h78;
         8'h35: base = 8'h79; 8'h1A: base = 8'h7A;
         default: begin
            letter = 1'b0;
            unique case (code)
               8'h45: base = 8'h30; 8'h16: base = 8'h31; 8'h1E: base = 8'h32;
               8'h26: base = 8'h33; 8'h25: base = 8'h34; 8'h2E: base = 8'h35;
               8'h36: base = 8'h36; 8'h3D: base = 8'h37; 8'h3E: base = 8'h38;
               8'h46: base = 8'h39;
               8'h29: base = 8'h20;
               8'h5A: base = 8'h0D;
               8'h0D: base = 8'h09;
               default: base = 8'h00;
            endcase
         end
      endcase
      ascii = (letter && upper) ? (base - 8'h20) : base;
   end
endmodule

// File: rtl/kbd_event_hold.sv
`timescale 1ns/1ps
module kbd_event_hold
   import kbd_dec_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       fire,
   input  kbd_event_t ev_in,
   input  logic       rd_ack,
   output logic       ready,
   output kbd_event_t ev_out
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ready  <= 1'b0;
         ev_out <= '0;
      end else if (fire) begin
         ready  <= 1'b1;
         ev_out <= ev_in;
      end else if (rd_ack) begin
         ready  <= 1'b0;
      end
   end

   // R9
   fire_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
      fire |=> ready);
   // R9
   read_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_ack && !fire) |=> !ready);
   // R9
   held_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (ready && !fire) |=> $stable(ev_out));
endmodule

// File: rtl/kbd_scan_decoder.sv
`timescale 1ns/1ps
module kbd_scan_decoder
   import kbd_dec_pkg::*;
#(
   parameter int unsigned TRAP_SHIFT  = 1,
   parameter logic [7:0]  EXT_CODE    = 8'hE0,
   parameter logic [7:0]  REL_CODE    = 8'hF0,
   parameter logic [7:0]  LSHIFT_CODE = 8'h12,
   parameter logic [7:0]  RSHIFT_CODE = 8'h59
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [7:0] byte_in,
   input  logic       byte_vld,
   input  logic       rd_ack,
   output logic       ev_ready,
   output logic [7:0] ev_code,
   output logic       ev_ext,
   output logic       ev_rel,
   output logic [7:0] ev_ascii,
   output logic       shift_on
);
   if (TRAP_SHIFT > 1) begin : g_bad_trap
      $error("TRAP_SHIFT must be 0 or 1");
   end
   if (EXT_CODE == REL_CODE) begin : g_bad_prefix
      $error("prefix codes must differ");
   end

   logic       key_done, ext_hold, rel_hold, is_shift, suppress, fire;
   logic [7:0] ascii_now;
   kbd_event_t ev_new, ev_q;

   kbd_prefix_track #(.EXT_CODE(EXT_CODE), .REL_CODE(REL_CODE)) u_prefix (
      .clk(clk), .rst(rst), .byte_in(byte_in), .byte_vld(byte_vld),
      .key_done(key_done), .ext_hold(ext_hold), .rel_hold(rel_hold));

   kbd_shift_track #(.LSHIFT_CODE(LSHIFT_CODE), .RSHIFT_CODE(RSHIFT_CODE)) u_shift (
      .clk(clk), .rst(rst), .key_done(key_done), .byte_in(byte_in),
      .rel_hold(rel_hold), .is_shift(is_shift), .shift_on(shift_on));

   kbd_ascii_map u_map (.code(byte_in), .upper(shift_on), .ascii(ascii_now));

   if (TRAP_SHIFT != 0) begin : g_trap
      assign suppress = is_shift;
   end else begin : g_pass
      assign suppress = 1'b0;
   end

   assign fire   = key_done && !suppress;
   assign ev_new = '{code: byte_in, ext: ext_hold, rel: rel_hold, ascii: ascii_now};

   kbd_event_hold u_hold (
      .clk(clk), .rst(rst), .fire(fire), .ev_in(ev_new), .rd_ack(rd_ack),
      .ready(ev_ready), .ev_out(ev_q));

   assign ev_code  = ev_q.code;
   assign ev_ext   = ev_q.ext;
   assign ev_rel   = ev_q.rel;
   assign ev_ascii = ev_q.ascii;

   // R1 R2
   prefix_no_event_chk: assert property (@(posedge clk) disable iff (rst)
      (byte_vld && (byte_in == EXT_CODE || byte_in == REL_CODE) && !rd_ack)
         |=> $stable(ev_ready));
   // R9
   ready_source_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ev_ready) |-> $past(byte_vld));
endmodule

// File: tb/kbd_scan_decoder_tb.sv
`timescale 1ns/1ps
module kbd_scan_decoder_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] byte_in = '0;
   logic       byte_vld = 1'b0;
   logic       rd_ack = 1'b0;
   logic       t_ready, t_ext, t_rel, t_shift;
   logic [7:0] t_code, t_ascii;
   logic       p_ready, p_ext, p_rel, p_shift;
   logic [7:0] p_code, p_ascii;
   int         n_tests = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   kbd_scan_decoder #(.TRAP_SHIFT(1)) u_dut (
      .clk(clk), .rst(rst), .byte_in(byte_in), .byte_vld(byte_vld), .rd_ack(rd_ack),
      .ev_ready(t_ready), .ev_code(t_code), .ev_ext(t_ext), .ev_rel(t_rel),
      .ev_ascii(t_ascii), .shift_on(t_shift));

   kbd_scan_decoder #(.TRAP_SHIFT(0)) u_dut_pass (
      .clk(clk), .rst(rst), .byte_in(byte_in), .byte_vld(byte_vld), .rd_ack(rd_ack),
      .ev_ready(p_ready), .ev_code(p_code), .ev_ext(p_ext), .ev_rel(p_rel),
      .ev_ascii(p_ascii), .shift_on(p_shift));

   // {byte, expected ascii, event, ext, rel, shift_on} for the trapping instance
   localparam int NV = 29;
   localparam logic [19:0] VEC [NV] = '{
      {8'h1C, 8'h61, 4'b1000}, {8'h12, 8'h00, 4'b0001}, {8'h1C, 8'h41, 4'b1001},
      {8'h16, 8'h31, 4'b1001}, {8'hF0, 8'h00, 4'b0001}, {8'h12, 8'h00, 4'b0000},
      {8'hF0, 8'h00, 4'b0000}, {8'h1C, 8'h61, 4'b1010}, {8'hE0, 8'h00, 4'b0000},
      {8'h11, 8'h00, 4'b1100}, {8'h11, 8'h00, 4'b1000}, {8'h59, 8'h00, 4'b0001},
      {8'hE0, 8'h00, 4'b0001}, {8'hF0, 8'h00, 4'b0001}, {8'h59, 8'h00, 4'b0000},
      {8'h29, 8'h20, 4'b1000}, {8'h0D, 8'h09, 4'b1000}, {8'h5A, 8'h0D, 4'b1000},
      {8'h45, 8'h30, 4'b1000}, {8'h76, 8'h00, 4'b1000}, {8'h1A, 8'h7A, 4'b1000},
      {8'h12, 8'h00, 4'b0001}, {8'h59, 8'h00, 4'b0001}, {8'hF0, 8'h00, 4'b0001},
      {8'h12, 8'h00, 4'b0001}, {8'h2D, 8'h52, 4'b1001}, {8'hF0, 8'h00, 4'b0001},
      {8'h59, 8'h00, 4'b0000}, {8'h2D, 8'h72, 4'b1000}
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      byte_in  = b;
      byte_vld = 1'b1;
      @(negedge clk);
      byte_vld = 1'b0;
   endtask

   task automatic read_ack();
      @(negedge clk);
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      do_reset();
      // R10 reset state
      check("R10", "ready after reset", t_ready, 0);
      check("R10", "shift after reset", t_shift, 0);

      for (int i = 0; i < NV; i++) begin
         logic [7:0] b, a;
         logic ev, ex, rl, sh;
         string req;
         {b, a, ev, ex, rl, sh} = VEC[i];
         send(b);
         if (b == 8'hE0)                    req = "R1";
         else if (b == 8'hF0)               req = "R2";
         else if (b == 8'h12 || b == 8'h59) req = "R7";
         else                               req = "R5";
         check(req, "ready", t_ready, ev);
         check("R4", "shift_on", t_shift, sh);
         if (ev) begin
            check(req, "code", t_code, b);
            check("R3", "ext", t_ext, ex);
            check("R3", "rel", t_rel, rl);
            check((a == 8'h61 || a == 8'h41 || a == 8'h7A || a >= 8'h52) ? "R5" : "R6",
                  "ascii", t_ascii, a);
            read_ack();
            check("R9", "ready after read", t_ready, 0);
         end
      end

      // R8 shift passes through without trapping
      do_reset();
      send(8'h59);
      check("R8", "pass ready", p_ready, 1);
      check("R8", "pass code", p_code, 8'h59);
      check("R8", "pass ascii", p_ascii, 8'h00);
      check("R7", "trap ready", t_ready, 0);
      check("R4", "pass shift_on", p_shift, 1);

      // R9 overwrite without a read
      read_ack();
      send(8'h1C);
      send(8'h32);
      check("R9", "overwrite ready", t_ready, 1);
      check("R9", "overwrite code", t_code, 8'h32);
      check("R5", "overwrite ascii", t_ascii, 8'h42);

      // R9 event and read in the same cycle: event wins
      @(negedge clk);
      byte_in = 8'h21; byte_vld = 1'b1; rd_ack = 1'b1;
      @(negedge clk);
      byte_vld = 1'b0; rd_ack = 1'b0;
      check("R9", "same-cycle ready", t_ready, 1);
      check("R9", "same-cycle code", t_code, 8'h21);

      // R10 reset clears held prefix and shift state
      send(8'h12);
      send(8'hE0);
      send(8'hF0);
      do_reset();
      check("R10", "shift cleared", t_shift, 0);
      check("R10", "ready cleared", t_ready, 0);
      check("R10", "code cleared", t_code, 0);
      send(8'h1C);
      check("R10", "ext after reset", t_ext, 0);
      check("R10", "rel after reset", t_rel, 0);
      check("R5", "lower after reset", t_ascii, 8'h61);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule